// File: doc/BRIEF.md
# Atomic Compare-and-Swap Execution Unit

This block is one stage of an atomic memory operation pipeline. It executes a compare-and-swap on a 4-, 8- or 16-byte location. It takes an already decoded operation with the following fields:

- the access width code
- the acquire and release bits
- the destination and swap-source register numbers
- a byte address
- a write-permission verdict for that address
- the current contents of the destination register, or register pair, as the expected value
- the swap-source register, or register pair, as the value to store

Before anything touches memory, the unit checks the operation for legality, alignment and permission. It then reads the location through a valid/ready memory port. It writes the location back: with the swap value when the old value equals the expected value, and with the old value otherwise.

The unit always returns the loaded old value for writeback into the destination register. It splits that value over an even/odd register pair for paired widths. It also raises two flags that tell the surrounding ordering logic whether acquire and release semantics apply. A failed compare never raises the release flag. The `XLEN` parameter picks a 32- or 64-bit hart. On a 64-bit hart the 16-byte form is paired. On a 32-bit hart the 8-byte form is paired and the 16-byte form is illegal. The unit takes one operation at a time and holds `busy` until its response cycle has passed.

Top module: `cas_unit`

## Requirements
- R1: When the loaded old value equals the expected value over the access width, the unit writes the swap value to memory and returns the old value on `wb_lo`/`wb_hi` with `wb_valid` high for one cycle together with `done`.
- R2: When the compare fails, the unit still issues exactly one write, carrying the unchanged old value, so memory keeps its content; it returns the old value just as on success.
- R3: With `XLEN`=64 and width code 0 (4 bytes), only bits 31:0 of `op_cmp_lo` take part in the compare, only bits 31:0 of `op_swp_lo` are stored, and `wb_lo` is the loaded 32-bit value sign-extended to 64 bits.
- R4: Width code 1 is 8 bytes and width code 2 is 16 bytes. With `XLEN`=64, width 1 uses `op_cmp_lo`/`op_swp_lo` alone with `wb_pair`=0. Width 2 is paired: the low 64 bits come from the `_lo` operands (even register), the high 64 bits come from the `_hi` operands (odd register), and the old value returns split the same way with `wb_pair`=1. Memory bytes are little-endian from the address.
- R5: A paired-width operation whose `op_rd` or `op_rs2` is odd ends with `exc_valid` and `exc_cause`=2 (illegal instruction) and issues no memory request.
- R6: Width code 3 is reserved and ends with `exc_cause`=2 and no memory request.
- R7: An address not aligned to the access width (4, 8 or 16 bytes) ends with `exc_cause`=6 (store/atomic address misaligned) and no memory request.
- R8: When `op_wr_ok` is low, the operation ends with `exc_cause`=7 (store access fault) and no memory request, even when the compare would have failed.
- R9: On a successful compare, `ord_acq` equals the operation's aq bit and `ord_rel` equals its rl bit during the `done` cycle.
- R10: On a failed compare, `ord_acq` equals the aq bit and `ord_rel` is 0 whatever the rl bit.
- R11: `busy` rises the cycle after an operation is accepted and stays high up to and including the `done` cycle. `op_valid` is ignored while `busy` is high. Each legal operation makes exactly one read followed by exactly one write, both at the operation's address. A request is held until it is accepted.
- R12: When several faults apply, illegal instruction (2) wins over misaligned (6), and misaligned wins over access fault (7).

Port widths: `XLEN` and `AW` are parameters (defaults 64 and 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered; taken when `busy` is low |
| op_size | input | 2 | Width code: 0 = 4 B, 1 = 8 B, 2 = 16 B, 3 reserved |
| op_aq | input | 1 | Acquire bit of the operation |
| op_rl | input | 1 | Release bit of the operation |
| op_rd | input | 5 | Destination register number |
| op_rs2 | input | 5 | Swap-source register number |
| op_addr | input | AW | Byte address |
| op_wr_ok | input | 1 | Write permission granted for the address |
| op_cmp_lo | input | XLEN | Expected value, destination register (even register when paired) |
| op_cmp_hi | input | XLEN | Expected value high half (odd register) |
| op_swp_lo | input | XLEN | Swap value, swap-source register (even when paired) |
| op_swp_hi | input | XLEN | Swap value high half (odd register) |
| busy | output | 1 | Operation in flight |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request byte address |
| mem_req_size | output | 2 | Request width code, same encoding as `op_size` |
| mem_req_wdata | output | 2*XLEN | Write data, little-endian from bit 0 |
| mem_rsp_valid | input | 1 | Read data returned (one cycle) |
| mem_rsp_rdata | input | 2*XLEN | Read data, little-endian from bit 0 |
| done | output | 1 | One-cycle response |
| exc_valid | output | 1 | Response is an exception |
| exc_cause | output | 4 | Exception cause code (2, 6 or 7) |
| wb_valid | output | 1 | Response carries a register writeback |
| wb_pair | output | 1 | Writeback covers the register pair |
| wb_rd | output | 5 | Destination register number |
| wb_lo | output | XLEN | Old value for the destination (even) register |
| wb_hi | output | XLEN | Old value high half for the odd register |
| ord_acq | output | 1 | Apply acquire ordering |
| ord_rel | output | 1 | Apply release ordering |

## Verification
The compare is tried with expected values that match the location exactly and with values that differ in a single half. For the 16-byte form, a difference confined to the odd-register half must still fail. For the 4-byte form, junk above bit 31 in both operands must be ignored, and a negative old word shows the sign extension. Faults are tried alone and in pairs, and a failing compare is combined with a missing permission, to show both the priority order and that no request reaches memory. A memory port that stalls `ready` at random and an operation held on `op_valid` during a transaction show that a held request stays put and that a new offer is not taken mid-flight.

// File: rtl/cas_pkg.sv
// Shared types and codes for the compare-and-swap execution unit.
// Assumes: width code and cause codes are fixed by the surrounding pipeline.
package cas_pkg;

    // Access width code carried from decode and onto the memory port
    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_DBL  = 2'd1,
        SZ_QUAD = 2'd2,
        SZ_RSV  = 2'd3
    } cas_size_e;

    // Transaction sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RREQ  = 3'd1,
        ST_RWAIT = 3'd2,
        ST_WREQ  = 3'd3,
        ST_RESP  = 3'd4
    } cas_state_e;

    localparam logic [3:0] CAUSE_ILLEGAL  = 4'd2;
    localparam logic [3:0] CAUSE_MISALIGN = 4'd6;
    localparam logic [3:0] CAUSE_ACCESS   = 4'd7;

endpackage

// File: rtl/cas_decode.sv
// Legality, alignment and permission screen for one compare-and-swap operation.
// Purely combinational; judges the operation as offered at the unit's input.
// Assumes: XLEN is 32 or 64; the permission verdict is already resolved upstream.
module cas_decode
    import cas_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cas_size_e   size_i,
    input  logic [4:0]  rd_i,
    input  logic [4:0]  rs2_i,
    input  logic [3:0]  addr_lo_i,
    input  logic        wr_ok_i,
    output logic        pair_o,
    output logic        fault_o,
    output logic [3:0]  cause_o
);

    localparam bit WIDE_HART = (XLEN >= 64);

    logic width_ok;
    logic odd_reg;
    logic illegal;
    logic misaligned;

    // Which widths exist on this hart and which of them use register pairs
    always_comb begin
        width_ok = (size_i == SZ_WORD) || (size_i == SZ_DBL) ||
                   ((size_i == SZ_QUAD) && WIDE_HART);
        pair_o   = WIDE_HART ? (size_i == SZ_QUAD) : (size_i == SZ_DBL);
        odd_reg  = rd_i[0] | rs2_i[0];
        illegal  = !width_ok || (pair_o && odd_reg);
    end

    // Natural alignment check against the access width
    always_comb begin
        case (size_i)
            SZ_WORD: misaligned = |addr_lo_i[1:0];
            SZ_DBL:  misaligned = |addr_lo_i[2:0];
            default: misaligned = |addr_lo_i[3:0];
        endcase
    end

    // Fault priority: illegal, then misaligned, then missing write permission
    always_comb begin
        fault_o = 1'b1;
        cause_o = CAUSE_ACCESS;
        if (illegal) begin
            cause_o = CAUSE_ILLEGAL;
        end else if (misaligned) begin
            cause_o = CAUSE_MISALIGN;
        end else if (!wr_ok_i) begin
            cause_o = CAUSE_ACCESS;
        end else begin
            fault_o = 1'b0;
        end
    end

endmodule

// File: rtl/cas_compare.sv
// Compare-before-write datapath: equality over the access width, choice of store
// data, and formatting of the old value for register writeback.
// Assumes: the old value arrives little-endian in the low bytes of old_i.
module cas_compare
    import cas_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cas_size_e             size_i,
    input  logic                  pair_i,
    input  logic [XLEN-1:0]       cmp_lo_i,
    input  logic [XLEN-1:0]       cmp_hi_i,
    input  logic [XLEN-1:0]       swp_lo_i,
    input  logic [XLEN-1:0]       swp_hi_i,
    input  logic [2*XLEN-1:0]     old_i,
    output logic                  match_o,
    output logic [2*XLEN-1:0]     st_data_o,
    output logic [XLEN-1:0]       wb_lo_o,
    output logic [XLEN-1:0]       wb_hi_o
);

    localparam int DW = 2 * XLEN;

    logic [DW-1:0]   lane_mask;
    logic [DW-1:0]   cmp_full;
    logic [DW-1:0]   swp_full;
    logic [XLEN-1:0] word_ext;
    int              nbits;

    // Bit mask covering the access width
    always_comb begin
        nbits = 32 << int'(size_i);
        for (int i = 0; i < DW; i++) begin
            lane_mask[i] = (i < nbits);
        end
    end

    // Assemble operands: pairs join odd register above even register
    always_comb begin
        cmp_full = pair_i ? {cmp_hi_i, cmp_lo_i} : {{XLEN{1'b0}}, cmp_lo_i};
        swp_full = pair_i ? {swp_hi_i, swp_lo_i} : {{XLEN{1'b0}}, swp_lo_i};
    end

    // Equality gate and store data selection (old value rewritten on mismatch)
    always_comb begin
        match_o   = ((old_i ^ cmp_full) & lane_mask) == '0;
        st_data_o = (match_o ? swp_full : old_i) & lane_mask;
    end

    // Word result: sign-extended on a wide hart, plain on a narrow one
    generate
        if (XLEN > 32) begin : g_wide_word
            assign word_ext = {{(XLEN-32){old_i[31]}}, old_i[31:0]};
        end else begin : g_narrow_word
            assign word_ext = old_i[XLEN-1:0];
        end
    endgenerate

    // Writeback split: pair halves, sign-extended word, or plain register
    always_comb begin
        wb_hi_o = '0;
        if (pair_i) begin
            wb_lo_o = old_i[XLEN-1:0];
            wb_hi_o = old_i[DW-1:XLEN];
        end else if (size_i == SZ_WORD) begin
            wb_lo_o = word_ext;
        end else begin
            wb_lo_o = old_i[XLEN-1:0];
        end
    end

endmodule

// File: rtl/cas_ctrl.sv
// Transaction sequencer: accept, read request, wait for data, write request,
// one-cycle response. A faulting operation skips straight to the response.
// Assumes: the memory returns exactly one read response per accepted read.
module cas_ctrl
    import cas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid_i,
    input  logic fault_i,
    input  logic req_ready_i,
    input  logic rsp_valid_i,
    output logic accept_o,
    output logic capture_o,
    output logic req_valid_o,
    output logic req_write_o,
    output logic done_o,
    output logic exc_o,
    output logic busy_o
);

    cas_state_e state_q, state_d;
    logic       exc_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (op_valid_i) state_d = fault_i ? ST_RESP : ST_RREQ;
            ST_RREQ:  if (req_ready_i) state_d = ST_RWAIT;
            ST_RWAIT: if (rsp_valid_i) state_d = ST_WREQ;
            ST_WREQ:  if (req_ready_i) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and exception flag for the current operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            exc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o) exc_q <= fault_i;
        end
    end

    // Decoded strobes for the datapath and the ports
    always_comb begin
        accept_o    = (state_q == ST_IDLE) && op_valid_i;
        capture_o   = (state_q == ST_RWAIT) && rsp_valid_i;
        req_valid_o = (state_q == ST_RREQ) || (state_q == ST_WREQ);
        req_write_o = (state_q == ST_WREQ);
        done_o      = (state_q == ST_RESP);
        exc_o       = exc_q;
        busy_o      = (state_q != ST_IDLE);
    end

    // R11: a request not yet taken stays offered with the same direction
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_write_o)));

    // R1: the response lasts a single cycle
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/cas_unit.sv
// Top of the compare-and-swap execution unit. Latches one operation, screens it,
// runs read-then-write on the memory port and returns the old value with
// acquire/release flags. The old value is always written back on a failed compare.
// Assumes: one operation at a time; the ordering flags are consumed elsewhere.
module cas_unit
    import cas_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_size,
    input  logic              op_aq,
    input  logic              op_rl,
    input  logic [4:0]        op_rd,
    input  logic [4:0]        op_rs2,
    input  logic [AW-1:0]     op_addr,
    input  logic              op_wr_ok,
    input  logic [XLEN-1:0]   op_cmp_lo,
    input  logic [XLEN-1:0]   op_cmp_hi,
    input  logic [XLEN-1:0]   op_swp_lo,
    input  logic [XLEN-1:0]   op_swp_hi,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [AW-1:0]     mem_req_addr,
    output logic [1:0]        mem_req_size,
    output logic [2*XLEN-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [2*XLEN-1:0] mem_rsp_rdata,
    output logic              done,
    output logic              exc_valid,
    output logic [3:0]        exc_cause,
    output logic              wb_valid,
    output logic              wb_pair,
    output logic [4:0]        wb_rd,
    output logic [XLEN-1:0]   wb_lo,
    output logic [XLEN-1:0]   wb_hi,
    output logic              ord_acq,
    output logic              ord_rel
);

    localparam int DW = 2 * XLEN;

    cas_size_e       in_size;
    logic            in_pair;
    logic            in_fault;
    logic [3:0]      in_cause;

    cas_size_e       size_q;
    logic            pair_q;
    logic            aq_q;
    logic            rl_q;
    logic [4:0]      rd_q;
    logic [AW-1:0]   addr_q;
    logic [3:0]      cause_q;
    logic [XLEN-1:0] cmp_lo_q, cmp_hi_q, swp_lo_q, swp_hi_q;
    logic [DW-1:0]   old_q;

    logic            accept, capture, exc_flag;
    logic            cmp_match;

    assign in_size = cas_size_e'(op_size);

    cas_decode #(.XLEN(XLEN)) i_decode (
        .size_i    (in_size),
        .rd_i      (op_rd),
        .rs2_i     (op_rs2),
        .addr_lo_i (op_addr[3:0]),
        .wr_ok_i   (op_wr_ok),
        .pair_o    (in_pair),
        .fault_o   (in_fault),
        .cause_o   (in_cause)
    );

    cas_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid_i  (op_valid),
        .fault_i     (in_fault),
        .req_ready_i (mem_req_ready),
        .rsp_valid_i (mem_rsp_valid),
        .accept_o    (accept),
        .capture_o   (capture),
        .req_valid_o (mem_req_valid),
        .req_write_o (mem_req_write),
        .done_o      (done),
        .exc_o       (exc_flag),
        .busy_o      (busy)
    );

    // Latch the accepted operation; ignored while a transaction is in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q   <= SZ_WORD;
            pair_q   <= 1'b0;
            aq_q     <= 1'b0;
            rl_q     <= 1'b0;
            rd_q     <= '0;
            addr_q   <= '0;
            cause_q  <= '0;
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
            swp_lo_q <= '0;
            swp_hi_q <= '0;
        end else if (accept) begin
            size_q   <= in_size;
            pair_q   <= in_pair;
            aq_q     <= op_aq;
            rl_q     <= op_rl;
            rd_q     <= op_rd;
            addr_q   <= op_addr;
            cause_q  <= in_cause;
            cmp_lo_q <= op_cmp_lo;
            cmp_hi_q <= op_cmp_hi;
            swp_lo_q <= op_swp_lo;
            swp_hi_q <= op_swp_hi;
        end
    end

    // Capture the old memory value when the read data returns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
        end else if (capture) begin
            old_q <= mem_rsp_rdata;
        end
    end

    cas_compare #(.XLEN(XLEN)) i_compare (
        .size_i    (size_q),
        .pair_i    (pair_q),
        .cmp_lo_i  (cmp_lo_q),
        .cmp_hi_i  (cmp_hi_q),
        .swp_lo_i  (swp_lo_q),
        .swp_hi_i  (swp_hi_q),
        .old_i     (old_q),
        .match_o   (cmp_match),
        .st_data_o (mem_req_wdata),
        .wb_lo_o   (wb_lo),
        .wb_hi_o   (wb_hi)
    );

    // Memory request fields come from the latched operation
    always_comb begin
        mem_req_addr = addr_q;
        mem_req_size = size_q;
    end

    // Response, writeback and ordering flags; release is dropped on mismatch
    always_comb begin
        exc_valid = done && exc_flag;
        exc_cause = cause_q;
        wb_valid  = done && !exc_flag;
        wb_pair   = pair_q;
        wb_rd     = rd_q;
        ord_acq   = wb_valid && aq_q;
        ord_rel   = wb_valid && rl_q && cmp_match;
    end

    // R11: busy only ever rises after an operation was offered
    assert_busy_after_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_valid));

    // R8: a faulting operation never had a memory request in the cycle before
    assert_fault_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(!mem_req_valid));

    // R2: every writeback follows an accepted write, match or not
    assert_write_before_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(mem_req_valid && mem_req_write && mem_req_ready));

    // R10: release ordering only when the compare matched
    assert_rel_needs_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ord_rel |-> (cmp_match && wb_valid));

endmodule

// File: tb/test_cas_unit.sv
// Self-checking bench: behavioural memory with random stalls and a per-operation
// reference computed from byte-array memory and the requirement text.
module test_cas_unit;

    localparam int XLEN = 64;
    localparam int AW   = 32;
    localparam int DW   = 2 * XLEN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [1:0]      op_size = '0;
    logic            op_aq = 1'b0, op_rl = 1'b0;
    logic [4:0]      op_rd = '0, op_rs2 = '0;
    logic [AW-1:0]   op_addr = '0;
    logic            op_wr_ok = 1'b1;
    logic [XLEN-1:0] op_cmp_lo = '0, op_cmp_hi = '0, op_swp_lo = '0, op_swp_hi = '0;
    logic            busy, mem_req_valid, mem_req_write, mem_rsp_valid;
    logic            mem_req_ready = 1'b0;
    logic [AW-1:0]   mem_req_addr;
    logic [1:0]      mem_req_size;
    logic [DW-1:0]   mem_req_wdata, mem_rsp_rdata;
    logic            done, exc_valid, wb_valid, wb_pair, ord_acq, ord_rel;
    logic [3:0]      exc_cause;
    logic [4:0]      wb_rd;
    logic [XLEN-1:0] wb_lo, wb_hi;

    always #10 clk = ~clk;   // 50 MHz

    cas_unit #(.XLEN(XLEN), .AW(AW)) i_cas_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_size(op_size),
        .op_aq(op_aq), .op_rl(op_rl), .op_rd(op_rd), .op_rs2(op_rs2),
        .op_addr(op_addr), .op_wr_ok(op_wr_ok), .op_cmp_lo(op_cmp_lo),
        .op_cmp_hi(op_cmp_hi), .op_swp_lo(op_swp_lo), .op_swp_hi(op_swp_hi),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .wb_valid(wb_valid), .wb_pair(wb_pair), .wb_rd(wb_rd),
        .wb_lo(wb_lo), .wb_hi(wb_hi), .ord_acq(ord_acq), .ord_rel(ord_rel)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [7:0]    mem [256];
    int            n_rd = 0, n_wr = 0, order_err = 0;
    logic [AW-1:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [7:0]    lfsr = 8'h5A;
    bit            pend = 1'b0, pend_w = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic [1:0]    pend_s = '0;
    logic [DW-1:0] pend_d = '0;

    initial mem_rsp_valid = 1'b0;
    initial mem_rsp_rdata = '0;

    function automatic logic [127:0] mem_get(input int a, input int nb);
        logic [127:0] v = '0;
        for (int k = 0; k < nb; k++) v[k*8 +: 8] = mem[(a + k) & 255];
        return v;
    endfunction

    // Acts on the handshake of the last edge, then offers ready for the next one
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (!rst_n) begin
            pend = 1'b0;
            mem_req_ready = 1'b0;
        end else begin
            if (pend) begin
                if (pend_w) begin
                    if (n_rd != n_wr + 1) order_err++;
                    for (int k = 0; k < (4 << pend_s); k++)
                        mem[(int'(pend_a) + k) & 255] = pend_d[k*8 +: 8];
                    n_wr++;
                    last_wr_addr = pend_a;
                end else begin
                    if (n_rd != n_wr) order_err++;
                    mem_rsp_rdata = mem_get(int'(pend_a), 4 << pend_s);
                    mem_rsp_valid = 1'b1;
                    n_rd++;
                    last_rd_addr = pend_a;
                end
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_req_ready = lfsr[0] | lfsr[2];
            pend   = mem_req_valid && mem_req_ready;
            pend_w = mem_req_write;
            pend_a = mem_req_addr;
            pend_s = mem_req_size;
            pend_d = mem_req_wdata;
        end
    end

    // ---------------- one operation with reference model ----------------
    task automatic run_op(input string tag, input logic [1:0] sz, input bit aq,
                          input bit rl, input logic [4:0] rd, input logic [4:0] rs2,
                          input int addr, input bit wrok,
                          input logic [63:0] clo, input logic [63:0] chi,
                          input logic [63:0] slo, input logic [63:0] shi,
                          input bit hold);
        int nb = 4 << sz;
        bit pair = (sz == 2'd2);
        logic [3:0] ecause = 4'd0;
        bit is_exc = 1'b1;
        logic [127:0] old = '0, mask, cmpv, swpv, newv;
        logic [63:0] e_lo = '0, e_hi = '0;
        bit match;
        int rd0, wr0, cyc;

        if (sz == 2'd3 || (pair && (rd[0] || rs2[0]))) ecause = 4'd2;
        else if ((addr % nb) != 0) ecause = 4'd6;
        else if (!wrok) ecause = 4'd7;
        else is_exc = 1'b0;
        mask = (nb >= 16) ? {128{1'b1}} : ((128'd1 << (nb * 8)) - 128'd1);
        if (!is_exc) old = mem_get(addr, nb);
        cmpv  = pair ? {chi, clo} : {64'd0, clo};
        swpv  = pair ? {shi, slo} : {64'd0, slo};
        match = ((old ^ cmpv) & mask) == '0;
        newv  = match ? (swpv & mask) : old;
        if (sz == 2'd0) e_lo = {{32{old[31]}}, old[31:0]};
        else e_lo = old[63:0];
        if (pair) e_hi = old[127:64];
        rd0 = n_rd; wr0 = n_wr;

        @(negedge clk);
        op_valid = 1'b1; op_size = sz; op_aq = aq; op_rl = rl; op_rd = rd;
        op_rs2 = rs2; op_addr = AW'(addr); op_wr_ok = wrok;
        op_cmp_lo = clo; op_cmp_hi = chi; op_swp_lo = slo; op_swp_hi = shi;
        @(negedge clk);
        if (hold) begin
            op_addr = AW'(addr + 16); op_swp_lo = ~slo; op_cmp_lo = ~clo;
        end else begin
            op_valid = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 400) begin
            chk(busy === 1'b1, {tag, " R11 busy in flight"}, 128'(busy), 128'd1);
            @(negedge clk);
            cyc++;
        end
        op_valid = 1'b0;
        chk(done === 1'b1, {tag, " R11 response arrives"}, 128'(done), 128'd1);
        chk(busy === 1'b1, {tag, " R11 busy at response"}, 128'(busy), 128'd1);
        chk(exc_valid === is_exc, {tag, " R5 R6 R7 R8 exception flag"},
            128'(exc_valid), 128'(is_exc));
        if (is_exc) begin
            chk(exc_cause === ecause, {tag, " R12 cause"}, 128'(exc_cause), 128'(ecause));
            chk(wb_valid === 1'b0, {tag, " R5 no writeback"}, 128'(wb_valid), 128'd0);
        end else begin
            chk(wb_valid === 1'b1, {tag, " R1 writeback"}, 128'(wb_valid), 128'd1);
            chk(wb_lo === e_lo, {tag, " R1 R3 old value low"}, 128'(wb_lo), 128'(e_lo));
            chk(wb_pair === pair, {tag, " R4 pair flag"}, 128'(wb_pair), 128'(pair));
            if (pair) chk(wb_hi === e_hi, {tag, " R4 old value high"},
                          128'(wb_hi), 128'(e_hi));
            chk(wb_rd === rd, {tag, " R1 dest reg"}, 128'(wb_rd), 128'(rd));
            chk(ord_acq === aq, {tag, " R9 R10 acquire"}, 128'(ord_acq), 128'(aq));
            chk(ord_rel === (rl && match), {tag, " R9 R10 release"},
                128'(ord_rel), 128'(rl && match));
        end
        @(negedge clk);
        chk(busy === 1'b0, {tag, " R11 idle after response"}, 128'(busy), 128'd0);
        chk(n_rd - rd0 == (is_exc ? 0 : 1), {tag, " R11 R7 read count"},
            128'(n_rd - rd0), 128'(is_exc ? 0 : 1));
        chk(n_wr - wr0 == (is_exc ? 0 : 1), {tag, " R2 R11 write count"},
            128'(n_wr - wr0), 128'(is_exc ? 0 : 1));
        if (!is_exc) begin
            chk(mem_get(addr, nb) === newv, {tag, " R1 R2 memory after"},
                mem_get(addr, nb), newv);
            chk(last_rd_addr == AW'(addr) && last_wr_addr == AW'(addr),
                {tag, " R11 request address"}, 128'(last_wr_addr), 128'(addr));
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0,
            "R11 reset state", {busy, done, mem_req_valid}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R11 idle after reset",
            {busy, done}, 128'd0);

        for (int k = 0; k < 4; k++) mem[16 + k] = 8'(32'h9ABC_DEF0 >> (8 * k));
        // R1 R3: word match with junk above bit 31, negative old word
        run_op("w-match", 2'd0, 1'b1, 1'b1, 5'd3, 5'd5, 16, 1'b1,
               64'hDEAD_BEEF_9ABC_DEF0, 64'd0, 64'h1111_2222_8000_1234, 64'd0, 1'b0);
        // R2 R10: word mismatch, aq and rl both set
        run_op("w-miss", 2'd0, 1'b1, 1'b1, 5'd3, 5'd5, 16, 1'b1,
               64'h0, 64'd0, 64'h5555_5555, 64'd0, 1'b0);
        // R4 R9: doubleword plain registers
        run_op("d-match", 2'd1, 1'b0, 1'b1, 5'd4, 5'd7, 32, 1'b1,
               mem_get(32, 8)[63:0], 64'hFFFF, 64'h0123_4567_89AB_CDEF, 64'd0, 1'b0);
        run_op("d-miss", 2'd1, 1'b0, 1'b1, 5'd4, 5'd7, 40, 1'b1,
               ~mem_get(40, 8)[63:0], 64'd0, 64'h77, 64'd0, 1'b0);
        // R4: quadword pair match, then mismatch only in high half
        run_op("q-match", 2'd2, 1'b1, 1'b0, 5'd6, 5'd8, 48, 1'b1,
               mem_get(48, 16)[63:0], mem_get(48, 16)[127:64],
               64'hA5A5_0000_1111_2222, 64'h3333_4444_5A5A_FFFF, 1'b0);
        run_op("q-hi-miss", 2'd2, 1'b1, 1'b1, 5'd10, 5'd12, 64, 1'b1,
               mem_get(64, 16)[63:0], mem_get(64, 16)[127:64] ^ 64'h1,
               64'h1, 64'h2, 1'b0);
        // R11: op_valid held with different data during the transaction
        run_op("q-hold", 2'd2, 1'b0, 1'b1, 5'd2, 5'd4, 80, 1'b1,
               mem_get(80, 16)[63:0], mem_get(80, 16)[127:64],
               64'hCAFE, 64'hF00D, 1'b1);
        // R5: odd registers on paired width
        run_op("q-odd-rd", 2'd2, 1'b0, 1'b0, 5'd7, 5'd8, 96, 1'b1,
               64'd0, 64'd0, 64'd0, 64'd0, 1'b0);
        run_op("q-odd-rs2", 2'd2, 1'b0, 1'b0, 5'd6, 5'd9, 96, 1'b1,
               64'd0, 64'd0, 64'd0, 64'd0, 1'b0);
        // R6: reserved width code
        run_op("rsv", 2'd3, 1'b0, 1'b0, 5'd2, 5'd2, 128, 1'b1,
               64'd0, 64'd0, 64'd0, 64'd0, 1'b0);
        // R7: misalignment at each width
        run_op("w-mis", 2'd0, 1'b0, 1'b0, 5'd1, 5'd2, 18, 1'b1,
               64'd0, 64'd0, 64'd0, 64'd0, 1'b0);
        run_op("d-mis", 2'd1, 1'b0, 1'b0, 5'd1, 5'd2, 36, 1'b1,
               64'd0, 64'd0, 64'd0, 64'd0, 1'b0);
        run_op("q-mis", 2'd2, 1'b0, 1'b0, 5'd2, 5'd4, 56, 1'b1,
               64'd0, 64'd0, 64'd0, 64'd0, 1'b0);
        // R8: no permission with a compare that would fail
        run_op("w-noperm", 2'd0, 1'b1, 1'b1, 5'd1, 5'd2, 20, 1'b0,
               ~64'(mem_get(20, 4)), 64'd0, 64'd0, 64'd0, 1'b0);
        // R12: priority between simultaneous faults
        run_op("prio-ill-mis", 2'd2, 1'b0, 1'b0, 5'd3, 5'd4, 52, 1'b0,
               64'd0, 64'd0, 64'd0, 64'd0, 1'b0);
        run_op("prio-mis-acc", 2'd1, 1'b0, 1'b0, 5'd3, 5'd4, 44, 1'b0,
               64'd0, 64'd0, 64'd0, 64'd0, 1'b0);
        // R1 R9: back-to-back matches with varied ordering bits
        for (int j = 0; j < 6; j++) begin
            run_op("w-loop", 2'd0, 1'(j), 1'(j >> 1), 5'(j), 5'(j + 1), 144 + 4 * j, 1'b1,
                   64'(mem_get(144 + 4 * j, 4)), 64'd0, 64'(j * 32'h1357_9BDF), 64'd0,
                   1'b0);
        end
        chk(order_err == 0, "R11 read precedes write", 128'(order_err), 128'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule